// File: doc/BRIEF.md
# Five-Step Hand-Fed 8-Bit Processor Core

This core is an 8-bit datapath run by a five-step sequencer. It has no memory and no program counter. An external agent presents one byte per step on `dataIn` while `operate` is held high. The core takes each byte as an instruction, as an operand or as nothing, depending on the step it is in. Every instruction uses two instruction-register loads. The first load configures how the A and B operands and the carry are captured. The second load selects the ALU or shifter operation whose result is written into the result register. The result register is always driven on `dataOut`.

The sequencer state is a 3-bit code chosen so that the load strobes decode cheaply. It is driven out on `stepCode`, so the feeding agent can align its bytes. All loads happen on the rising clock edge as synchronous enables. The enables are decoded from the registered step, so a byte is captured on the edge that ends the step in which it was presented.

Top module: `mp_core`

## Requirements
- R1: While `rst` is high at a rising edge, the step becomes idle (`stepCode` = 000), and the IR, A, B, result and carry registers become zero, so `dataOut` reads 0.
- R2: With `operate` high, `stepCode` advances on each rising edge through idle 000 → step1 001 → step2 100 → step3 010 → step4 101 → step5 110, and then returns to step1 001. The unused codes 011 and 111 go to step4 101.
- R3: With `operate` low at a rising edge, the next step is idle from any step. In idle no register loads, so `dataOut` holds its value.
- R4: On the edge that ends a step, the core loads as follows. Step1 loads IR from `dataIn`. Step2 loads A. Step3 loads B from `dataIn` and loads the carry. Step4 loads IR from `dataIn`. Step5 loads the result register and the carry.
- R5: IR[6:4] selects the ALU operation. 000 gives 0. 001 gives B + ~A + cin. 010 gives A + ~B + cin. 011 gives A + B + cin. 100 gives A xor B. 101 gives A or B. 110 gives A and B. 111 gives all ones. Only the three add forms produce a carry-out; the other operations give carry-out 0.
- R6: IR[1] selects the ALU carry-in: 0 gives a constant 1, and 1 gives the carry register.
- R7: IR[6:4] also selects the shifter operation, applied to the result register with shift-in 0. 000 passes the value and gives carry 0. 001 rotates left. 010 and 011 shift left with a 0 in. 100 rotates right. 101 and 111 shift right logically. 110 shifts right arithmetically. Left forms give carry = bit 7; right forms give carry = bit 0.
- R8: IR[2] selects the result register's source (0 = shifter, 1 = ALU). The carry register loads the carry-out of the same unit.
- R9: IR[0] selects the A register's source: 0 = shifter output, 1 = `dataIn`.
- R10: IR bits 7 and 3 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| operate | input | 1 | Run enable for the step sequencer |
| dataIn | input | 8 | Instruction or operand byte for the current step |
| dataOut | output | 8 | Result register contents |
| stepCode | output | 3 | Registered step code |

## Verification
A byte presented during a step is captured on the edge that ends it. The result of an instruction is therefore visible on `dataOut` one edge after step5, which is five edges after the edge that entered step1. The bench drives on falling edges and samples on the falling edge after each rising edge, so it always reads the value settled after that edge. Carry effects that cannot be seen directly are checked through a following instruction whose sum depends on them. The shifter forms are each checked on a known result-register value that an earlier instruction primes.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int FN_W = 3;

  localparam logic [2:0] ST_IDLE = 3'b000;
  localparam logic [2:0] ST_S1   = 3'b001;
  localparam logic [2:0] ST_S2   = 3'b100;
  localparam logic [2:0] ST_S3   = 3'b010;
  localparam logic [2:0] ST_S4   = 3'b101;
  localparam logic [2:0] ST_S5   = 3'b110;

  // IR field positions
  localparam int IR_SEL_A   = 0;
  localparam int IR_SEL_CIN = 1;
  localparam int IR_SEL_RES = 2;
  localparam int IR_FN_LO   = 4;

  typedef struct packed {
    logic ldIr;
    logic ldA;
    logic ldB;
    logic ldC;
    logic ldRes;
  } strobeT;
endpackage

// File: rtl/mp_alu.sv
module mp_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0]          aIn,
  input  logic [W-1:0]          bIn,
  input  logic [mp_pkg::FN_W-1:0] fn,
  input  logic                  cin,
  output logic [W-1:0]          y,
  output logic                  cout
);
  logic [W:0] sum;
  logic [W:0] opX;
  logic [W:0] opY;
  logic       isAdd;

  always_comb begin
    opX   = {1'b0, aIn};
    opY   = {1'b0, bIn};
    isAdd = 1'b0;
    unique case (fn)
      3'b001: begin opX = {1'b0, bIn}; opY = {1'b0, ~aIn}; isAdd = 1'b1; end
      3'b010: begin opX = {1'b0, aIn}; opY = {1'b0, ~bIn}; isAdd = 1'b1; end
      3'b011: begin opX = {1'b0, aIn}; opY = {1'b0, bIn};  isAdd = 1'b1; end
      default: ;
    endcase
    sum = opX + opY + {{W{1'b0}}, cin};
  end

  always_comb begin
    cout = 1'b0;
    unique case (fn)
      3'b000: y = '0;
      3'b100: y = aIn ^ bIn;
      3'b101: y = aIn | bIn;
      3'b110: y = aIn & bIn;
      3'b111: y = '1;
      default: begin y = sum[W-1:0]; cout = isAdd & sum[W]; end
    endcase
  end
endmodule

// File: rtl/mp_shifter.sv
module mp_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0]            din,
  input  logic [mp_pkg::FN_W-1:0] fn,
  input  logic                    cin,
  output logic [W-1:0]            y,
  output logic                    cout
);
  logic goesLeft;
  logic fillBit;

  assign goesLeft = ~fn[2];

  always_comb begin
    unique case (fn[1:0])
      2'b00:   fillBit = goesLeft ? 1'b0 : din[0];
      2'b01:   fillBit = goesLeft ? din[W-1] : 1'b0;
      2'b10:   fillBit = goesLeft ? 1'b0 : din[W-1];
      default: fillBit = cin;
    endcase
  end

  always_comb begin
    if (fn == 3'b000) begin
      y    = din;
      cout = 1'b0;
    end else if (goesLeft) begin
      y    = {din[W-2:0], fillBit};
      cout = din[W-1];
    end else begin
      y    = {fillBit, din[W-1:1]};
      cout = din[0];
    end
  end
endmodule

// File: rtl/mp_control.sv
module mp_control
  import mp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       operate,
  output logic [2:0] stepCode,
  output strobeT     strobes
);
  logic [2:0] stepQ;
  logic [2:0] stepD;

  always_comb begin
    if (!operate) stepD = ST_IDLE;
    else begin
      case (stepQ)
        ST_IDLE: stepD = ST_S1;
        ST_S1:   stepD = ST_S2;
        ST_S2:   stepD = ST_S3;
        ST_S3:   stepD = ST_S4;
        ST_S4:   stepD = ST_S5;
        ST_S5:   stepD = ST_S1;
        default: stepD = ST_S4;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stepQ <= ST_IDLE;
    else     stepQ <= stepD;
  end

  always_comb begin
    strobes       = '0;
    strobes.ldIr  = (stepQ == ST_S1) || (stepQ == ST_S4);
    strobes.ldA   = (stepQ == ST_S2);
    strobes.ldB   = (stepQ == ST_S3);
    strobes.ldC   = (stepQ == ST_S3) || (stepQ == ST_S5);
    strobes.ldRes = (stepQ == ST_S5);
  end

  assign stepCode = stepQ;

  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (operate && stepQ == ST_IDLE) |=> stepQ == ST_S1);
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (operate && stepQ == ST_S5) |=> stepQ == ST_S1);
  a_r2_unused: assert property (@(posedge clk) disable iff (rst)
    (operate && (stepQ == 3'b011 || stepQ == 3'b111)) |=> stepQ == ST_S4);
  a_r3_drop: assert property (@(posedge clk) disable iff (rst)
    !operate |=> stepQ == ST_IDLE);
  a_r4_one_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.ldIr, strobes.ldA, strobes.ldB, strobes.ldRes}));
endmodule

// File: rtl/mp_datapath.sv
module mp_datapath
  import mp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  strobeT       strobes,
  input  logic [W-1:0] dataIn,
  output logic [W-1:0] resOut
);
  logic [W-1:0]    irQ, aQ, bQ, resQ;
  logic            cQ;
  logic [FN_W-1:0] fnSel;
  logic            aluCin;
  logic [W-1:0]    aluY, shY;
  logic            aluCout, shCout;
  logic [W-1:0]    aNext, resNext;
  logic            cNext;

  assign fnSel  = irQ[IR_FN_LO +: FN_W];
  assign aluCin = irQ[IR_SEL_CIN] ? cQ : 1'b1;

  mp_alu #(.W(W)) uAlu (
    .aIn(aQ), .bIn(bQ), .fn(fnSel), .cin(aluCin), .y(aluY), .cout(aluCout)
  );

  mp_shifter #(.W(W)) uShift (
    .din(resQ), .fn(fnSel), .cin(1'b0), .y(shY), .cout(shCout)
  );

  assign aNext   = irQ[IR_SEL_A]   ? dataIn  : shY;
  assign resNext = irQ[IR_SEL_RES] ? aluY    : shY;
  assign cNext   = irQ[IR_SEL_RES] ? aluCout : shCout;

  always_ff @(posedge clk) begin
    if (rst) begin
      irQ <= '0; aQ <= '0; bQ <= '0; resQ <= '0; cQ <= 1'b0;
    end else begin
      if (strobes.ldIr)  irQ  <= dataIn;
      if (strobes.ldA)   aQ   <= aNext;
      if (strobes.ldB)   bQ   <= dataIn;
      if (strobes.ldC)   cQ   <= cNext;
      if (strobes.ldRes) resQ <= resNext;
    end
  end

  assign resOut = resQ;

  a_r8_alu_result: assert property (@(posedge clk) disable iff (rst)
    (strobes.ldRes && irQ[IR_SEL_RES]) |=> resQ == $past(aluY));
  a_r8_shift_result: assert property (@(posedge clk) disable iff (rst)
    (strobes.ldRes && !irQ[IR_SEL_RES]) |=> resQ == $past(shY));
  a_r9_a_from_input: assert property (@(posedge clk) disable iff (rst)
    (strobes.ldA && irQ[IR_SEL_A]) |=> aQ == $past(dataIn));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (strobes == '0) |=> ($stable(resQ) && $stable(aQ) && $stable(irQ)));
endmodule

// File: rtl/mp_core.sv
module mp_core
  import mp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         operate,
  input  logic [W-1:0] dataIn,
  output logic [W-1:0] dataOut,
  output logic [2:0]   stepCode
);
  strobeT strobes;

  mp_control uCtrl (
    .clk(clk), .rst(rst), .operate(operate), .stepCode(stepCode), .strobes(strobes)
  );

  mp_datapath #(.W(W)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .dataIn(dataIn), .resOut(dataOut)
  );
endmodule

// File: tb/sim_mp_core.sv
`timescale 1ns/100ps
module sim_mp_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       operate = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic [2:0] stepCode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mp_core u0 (
    .clk(clk), .rst(rst), .operate(operate), .dataIn(dataIn),
    .dataOut(dataOut), .stepCode(stepCode)
  );

  // {second instruction, A byte, B byte, expected result}
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {8'h36, 8'h5A, 8'h3C, 8'h96},  // R5 add, cin=C=0
    {8'h36, 8'hF0, 8'h20, 8'h10},  // R5 add wrap
    {8'h34, 8'h5A, 8'h3C, 8'h97},  // R6 cin constant 1
    {8'h14, 8'h05, 8'h12, 8'h0D},  // R5 B-A
    {8'h24, 8'h05, 8'h12, 8'hF3},  // R5 A-B
    {8'h44, 8'hA5, 8'hFF, 8'h5A},  // R5 xor
    {8'h54, 8'h0F, 8'h30, 8'h3F},  // R5 or
    {8'h64, 8'hF0, 8'h3C, 8'h30},  // R5 and
    {8'h74, 8'h12, 8'h34, 8'hFF},  // R5 all ones
    {8'h04, 8'h12, 8'h34, 8'h00},  // R5 zero
    {8'hBE, 8'h01, 8'h02, 8'h03},  // R10 bits 7,3 set
    {8'hB6, 8'h7F, 8'h01, 8'h80}   // R10 add with spare bits set
  };

  // shifter results on 0x96 for fn = 0..7 (R7)
  localparam logic [7:0] SHX [8] = '{
    8'h96, 8'h2D, 8'h2C, 8'h2C, 8'h4B, 8'h4B, 8'hCB, 8'h4B
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Starts and ends in idle at a falling edge; result sampled afterwards.
  task automatic runCycle(input logic [7:0] i1, input logic [7:0] aB,
                          input logic [7:0] bB, input logic [7:0] i2,
                          input bit seqCheck);
    operate = 1'b1;
    tick();
    if (seqCheck) chk("R2 step1 code", {5'd0, stepCode}, 8'h01);
    dataIn = i1; tick();
    if (seqCheck) chk("R2 step2 code", {5'd0, stepCode}, 8'h04);
    dataIn = aB; tick();
    if (seqCheck) chk("R2 step3 code", {5'd0, stepCode}, 8'h02);
    dataIn = bB; tick();
    if (seqCheck) chk("R2 step4 code", {5'd0, stepCode}, 8'h05);
    dataIn = i2; tick();
    if (seqCheck) chk("R2 step5 code", {5'd0, stepCode}, 8'h06);
    dataIn = 8'hEE; tick();
    if (seqCheck) chk("R2 wrap to step1", {5'd0, stepCode}, 8'h01);
    operate = 1'b0; tick();
  endtask

  initial begin
    logic [7:0] held;
    @(negedge clk);
    tick(); tick();
    chk("R1 reset dataOut", dataOut, 8'h00);
    chk("R1 reset step", {5'd0, stepCode}, 8'h00);
    rst = 1'b0;
    tick();
    chk("R3 idle with operate low", {5'd0, stepCode}, 8'h00);

    // R4 step order and loads, R2 encoding
    runCycle(8'h01, 8'h5A, 8'h3C, 8'h36, 1'b1);
    chk("R4 result after step5", dataOut, 8'h96);

    for (int i = 0; i < NV; i++) begin
      runCycle(8'h01, VEC[i][23:16], VEC[i][15:8], VEC[i][31:24], 1'b0);
      chk($sformatf("R5/R6/R10 vector %0d", i), dataOut, VEC[i][7:0]);
    end

    // R7 shifter forms on a primed result register
    for (int f = 0; f < 8; f++) begin
      runCycle(8'h01, 8'h5A, 8'h3C, 8'h36, 1'b0);
      runCycle(8'h01, 8'h00, 8'h00, {1'b0, f[2:0], 4'h0}, 1'b0);
      chk($sformatf("R7 shift fn %0d", f), dataOut, SHX[f]);
    end

    // R9: A from shifter (rotate left of 0x96 = 0x2D), R8: carry from shifter = 1
    runCycle(8'h01, 8'h5A, 8'h3C, 8'h36, 1'b0);
    runCycle(8'h10, 8'hAA, 8'h00, 8'h36, 1'b0);
    chk("R9 A from shifter, R8 shifter carry", dataOut, 8'h2E);

    // R8/R6: carry left by step5 feeds the step3 sum of the next cycle
    runCycle(8'h01, 8'hF0, 8'h20, 8'h36, 1'b0);
    runCycle(8'h37, 8'hDF, 8'h00, 8'h36, 1'b0);
    chk("R8 ALU carry into step3 carry", dataOut, 8'hE0);

    // R3: drop operate mid-instruction
    runCycle(8'h01, 8'h11, 8'h22, 8'h36, 1'b0);
    held = dataOut;
    operate = 1'b1; tick();
    dataIn = 8'h04; tick();
    operate = 1'b0; dataIn = 8'h33; tick();
    chk("R3 drop to idle", {5'd0, stepCode}, 8'h00);
    for (int k = 0; k < 4; k++) begin dataIn = 8'hFF; tick(); end
    chk("R3 idle holds result", dataOut, held);
    runCycle(8'h01, 8'h01, 8'h01, 8'h36, 1'b0);
    chk("R3 clean restart", dataOut, 8'h02);

    // R1: reset in the middle of a run
    operate = 1'b1; tick(); tick();
    rst = 1'b1; tick();
    chk("R1 mid-run reset step", {5'd0, stepCode}, 8'h00);
    chk("R1 mid-run reset dataOut", dataOut, 8'h00);
    rst = 1'b0; operate = 1'b0; tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule